// File: doc/BRIEF.md
# Store-Set Identifier Table with Set Merging

This block is the first stage of a memory dependence predictor in an out-of-order core. It holds a direct-mapped table, indexed by instruction address, in which each entry may carry a store-set identifier. Two read ports serve freshly fetched loads and stores: each returns whether the instruction belongs to a store set and, if so, which one. A separate training port receives a load/store pair that has just caused a memory-order violation. The block then places both instructions in a common set. If they already sit in two different sets, those sets are merged toward the smaller identifier.

The table has no tags, and each entry holds one identifier, so a store can be a member of only one set at a time. Stale groupings are dropped by a background sweeper. After a long programmable interval of idle counting, it invalidates every entry, one per cycle. Misprediction recovery elsewhere in the core never touches the table.

Top module: `ssid_table`

## Requirements
- R1: After reset every entry reads as invalid on both read ports.
- R2: The load's entry is selected by the low IDX_W bits of its word address (byte address bits [IDX_W+1:2]). The upper word-address bits only feed the hash, so loads that differ only there share one entry.
- R3: When neither the load entry nor the store entry is valid, both become valid with the fresh identifier. That identifier is bit b = waddr[b] XOR waddr[SSID_W+b] of the load word address.
- R4: When only the load entry is valid, the store entry becomes valid with the load's identifier, and the load entry is unchanged.
- R5: When only the store entry is valid, the load entry becomes valid with the store's identifier, and the store entry is unchanged.
- R6: When both entries are valid with different identifiers, the entry holding the larger value is rewritten to the smaller one. The other entry is left as it is.
- R7: An update whose two entries already hold the same valid identifier changes nothing. No update ever alters an entry other than the load's and the store's.
- R8: Reads are combinational from stored state. An update is seen by reads in the cycle after it is presented, and not in the same cycle.
- R9: Counting clock edges after reset release as 1, 2, …, entry j is invalidated at edge SWEEP_INTERVAL+1+j. The pattern repeats with period SWEEP_INTERVAL+2^IDX_W.
- R10: An update that writes an entry in the same cycle that the sweeper clears that entry wins. The entry ends valid with the update's identifier.
- R11: The two read ports look up different entries independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_pc | input | IDX_W | Read port 0 index (word address low bits) |
| rd0_valid | output | 1 | Port 0 entry holds a store set |
| rd0_ssid | output | SSID_W | Port 0 identifier |
| rd1_pc | input | IDX_W | Read port 1 index (word address low bits) |
| rd1_valid | output | 1 | Port 1 entry holds a store set |
| rd1_ssid | output | SSID_W | Port 1 identifier |
| upd_en | input | 1 | A violation pair is presented this cycle |
| upd_load_pc | input | ADDR_W | Word address of the violating load |
| upd_store_pc | input | IDX_W | Index of the violating store |

## Verification
Training results are due one edge after the update is presented. The bench therefore samples half a cycle before that edge, expecting the old contents, and half a cycle after it, expecting the new ones. It then reads back the whole table two entries per cycle against an arithmetic model. Sweep results are due at a fixed edge count after reset release. The bench keeps its own edge counter and probes each entry exactly one cycle before and at the edge that should clear it. It times an update to land on the very edge that clears its entry.

// File: rtl/ssid_pkg.sv
package ssid_pkg;

    typedef enum logic [2:0] {
        RULE_IDLE,
        RULE_FRESH,
        RULE_LOAD_TO_STORE,
        RULE_STORE_TO_LOAD,
        RULE_MERGE_LOAD_WINS,
        RULE_MERGE_STORE_WINS,
        RULE_SAME
    } rule_e;

    typedef enum logic {
        PH_COUNT,
        PH_CLEAR
    } sweep_ph_e;

endpackage

// File: rtl/ssid_hash.sv
module ssid_hash #(
    parameter int IDX_W  = 12,
    parameter int SSID_W = 7,
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] waddr,
    output logic [IDX_W-1:0]  idx,
    output logic [SSID_W-1:0] fold
);
    assign idx = waddr[IDX_W-1:0];

    for (genvar b = 0; b < SSID_W; b++) begin : g_fold
        assign fold[b] = waddr[b] ^ waddr[SSID_W+b];
    end
endmodule

// File: rtl/ssid_rules.sv
module ssid_rules
    import ssid_pkg::*;
#(
    parameter int SSID_W = 7
) (
    input  logic              upd_en,
    input  logic              ld_v,
    input  logic [SSID_W-1:0] ld_id,
    input  logic              st_v,
    input  logic [SSID_W-1:0] st_id,
    input  logic [SSID_W-1:0] fresh_id,
    output logic              ld_we,
    output logic [SSID_W-1:0] ld_wid,
    output logic              st_we,
    output logic [SSID_W-1:0] st_wid
);
    rule_e rule;

    always_comb begin
        rule = RULE_IDLE;
        if (upd_en) begin
            unique case ({ld_v, st_v})
                2'b00:   rule = RULE_FRESH;
                2'b10:   rule = RULE_LOAD_TO_STORE;
                2'b01:   rule = RULE_STORE_TO_LOAD;
                default: begin
                    if (ld_id == st_id)     rule = RULE_SAME;
                    else if (ld_id < st_id) rule = RULE_MERGE_LOAD_WINS;
                    else                    rule = RULE_MERGE_STORE_WINS;
                end
            endcase
        end
    end

    always_comb begin
        ld_we  = 1'b0;
        st_we  = 1'b0;
        ld_wid = st_id;
        st_wid = ld_id;
        unique case (rule)
            RULE_FRESH: begin
                ld_we  = 1'b1;
                st_we  = 1'b1;
                ld_wid = fresh_id;
                st_wid = fresh_id;
            end
            RULE_LOAD_TO_STORE,
            RULE_MERGE_LOAD_WINS:  st_we = 1'b1;
            RULE_STORE_TO_LOAD,
            RULE_MERGE_STORE_WINS: ld_we = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ssid_sweep.sv
module ssid_sweep
    import ssid_pkg::*;
#(
    parameter int IDX_W          = 12,
    parameter int SWEEP_INTERVAL = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam int IC_W    = (SWEEP_INTERVAL > 2) ? $clog2(SWEEP_INTERVAL) : 1;
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        sweep_ph_e        phase;
        logic [IC_W-1:0]  ic;
        logic [IDX_W-1:0] ptr;
    } sweep_t;

    sweep_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        unique case (sw_q.phase)
            PH_COUNT: begin
                if (sw_q.ic == IC_W'(SWEEP_INTERVAL - 1)) begin
                    sw_d.phase = PH_CLEAR;
                    sw_d.ic    = '0;
                    sw_d.ptr   = '0;
                end else begin
                    sw_d.ic = sw_q.ic + 1'b1;
                end
            end
            PH_CLEAR: begin
                if (sw_q.ptr == IDX_W'(ENTRIES - 1)) sw_d.phase = PH_COUNT;
                else                                  sw_d.ptr   = sw_q.ptr + 1'b1;
            end
            default: sw_d.phase = PH_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q.phase <= PH_COUNT;
            sw_q.ic    <= '0;
            sw_q.ptr   <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign clr_en  = (sw_q.phase == PH_CLEAR);
    assign clr_idx = sw_q.ptr;
endmodule

// File: rtl/ssid_array.sv
module ssid_array #(
    parameter int IDX_W  = 12,
    parameter int SSID_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_en,
    input  logic [IDX_W-1:0]               clr_idx,
    input  logic                           st_we,
    input  logic [IDX_W-1:0]               st_idx,
    input  logic [SSID_W-1:0]              st_wid,
    input  logic                           ld_we,
    input  logic [IDX_W-1:0]               ld_idx,
    input  logic [SSID_W-1:0]              ld_wid,
    output logic [(1<<IDX_W)-1:0]          valid_o,
    output logic [(1<<IDX_W)-1:0][SSID_W-1:0] id_o
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][SSID_W-1:0] id;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // Order sets priority: sweep clear lowest, load write highest.
    always_comb begin
        tbl_d = tbl_q;
        if (clr_en) tbl_d.valid[clr_idx] = 1'b0;
        if (st_we) begin
            tbl_d.valid[st_idx] = 1'b1;
            tbl_d.id[st_idx]    = st_wid;
        end
        if (ld_we) begin
            tbl_d.valid[ld_idx] = 1'b1;
            tbl_d.id[ld_idx]    = ld_wid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q.valid <= '0;
            tbl_q.id    <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign valid_o = tbl_q.valid;
    assign id_o    = tbl_q.id;
endmodule

// File: rtl/ssid_table.sv
module ssid_table #(
    parameter int IDX_W          = 12,
    parameter int SSID_W         = 7,
    parameter int ADDR_W         = (IDX_W > 2*SSID_W) ? IDX_W : 2*SSID_W,
    parameter int SWEEP_INTERVAL = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_pc,
    output logic              rd0_valid,
    output logic [SSID_W-1:0] rd0_ssid,
    input  logic [IDX_W-1:0]  rd1_pc,
    output logic              rd1_valid,
    output logic [SSID_W-1:0] rd1_ssid,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_load_pc,
    input  logic [IDX_W-1:0]  upd_store_pc
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int N_LK    = 4;

    logic [ENTRIES-1:0]             tbl_valid;
    logic [ENTRIES-1:0][SSID_W-1:0] tbl_id;

    logic [IDX_W-1:0]  ld_idx;
    logic [SSID_W-1:0] fresh_id;

    logic [N_LK-1:0][IDX_W-1:0]  lk_idx;
    logic [N_LK-1:0]             lk_v;
    logic [N_LK-1:0][SSID_W-1:0] lk_id;

    logic              ld_cur_v, st_cur_v;
    logic [SSID_W-1:0] ld_cur_id, st_cur_id;
    logic              ld_we, st_we;
    logic [SSID_W-1:0] ld_wid, st_wid;
    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;

    ssid_hash #(.IDX_W(IDX_W), .SSID_W(SSID_W), .ADDR_W(ADDR_W)) u_hash (
        .waddr (upd_load_pc),
        .idx   (ld_idx),
        .fold  (fresh_id)
    );

    assign lk_idx[0] = rd0_pc;
    assign lk_idx[1] = rd1_pc;
    assign lk_idx[2] = ld_idx;
    assign lk_idx[3] = upd_store_pc;

    for (genvar p = 0; p < N_LK; p++) begin : g_lookup
        assign lk_v[p]  = tbl_valid[lk_idx[p]];
        assign lk_id[p] = tbl_id[lk_idx[p]];
    end

    assign rd0_valid = lk_v[0];
    assign rd0_ssid  = lk_id[0];
    assign rd1_valid = lk_v[1];
    assign rd1_ssid  = lk_id[1];
    assign ld_cur_v  = lk_v[2];
    assign ld_cur_id = lk_id[2];
    assign st_cur_v  = lk_v[3];
    assign st_cur_id = lk_id[3];

    ssid_rules #(.SSID_W(SSID_W)) u_rules (
        .upd_en   (upd_en),
        .ld_v     (ld_cur_v),
        .ld_id    (ld_cur_id),
        .st_v     (st_cur_v),
        .st_id    (st_cur_id),
        .fresh_id (fresh_id),
        .ld_we    (ld_we),
        .ld_wid   (ld_wid),
        .st_we    (st_we),
        .st_wid   (st_wid)
    );

    ssid_sweep #(.IDX_W(IDX_W), .SWEEP_INTERVAL(SWEEP_INTERVAL)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    ssid_array #(.IDX_W(IDX_W), .SSID_W(SSID_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .st_we   (st_we),
        .st_idx  (upd_store_pc),
        .st_wid  (st_wid),
        .ld_we   (ld_we),
        .ld_idx  (ld_idx),
        .ld_wid  (ld_wid),
        .valid_o (tbl_valid),
        .id_o    (tbl_id)
    );
endmodule

// File: rtl/ssid_table_chk.sv
module ssid_table_chk #(
    parameter int IDX_W          = 12,
    parameter int SSID_W         = 7,
    parameter int SWEEP_INTERVAL = 1000000
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                upd_en,
    input logic                                ld_cur_v,
    input logic [SSID_W-1:0]                   ld_cur_id,
    input logic                                st_cur_v,
    input logic [SSID_W-1:0]                   st_cur_id,
    input logic [SSID_W-1:0]                   fresh_id,
    input logic                                ld_we,
    input logic [SSID_W-1:0]                   ld_wid,
    input logic [IDX_W-1:0]                    ld_idx,
    input logic                                st_we,
    input logic [SSID_W-1:0]                   st_wid,
    input logic [IDX_W-1:0]                    st_idx,
    input logic                                clr_en,
    input logic [IDX_W-1:0]                    clr_idx,
    input logic [(1<<IDX_W)-1:0]               tbl_valid,
    input logic [(1<<IDX_W)-1:0][SSID_W-1:0]   tbl_id
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int PERIOD  = SWEEP_INTERVAL + ENTRIES;
    localparam int CYC_W   = $clog2(PERIOD + 1);

    logic [CYC_W-1:0] cyc_q;
    logic             in_window;
    logic             upd_hits_clr;

    always_ff @(posedge clk) begin
        if (!rst_n)                                  cyc_q <= '0;
        else if (cyc_q == CYC_W'(PERIOD - 1))        cyc_q <= '0;
        else                                         cyc_q <= cyc_q + 1'b1;
    end

    assign in_window    = (cyc_q >= CYC_W'(SWEEP_INTERVAL));
    assign upd_hits_clr = (ld_we && ld_idx == clr_idx) || (st_we && st_idx == clr_idx);

    assert_sweep_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en == in_window) &&
        (!clr_en || clr_idx == IDX_W'(cyc_q - CYC_W'(SWEEP_INTERVAL))));

    assert_sweep_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !upd_hits_clr |=> !tbl_valid[$past(clr_idx)]);

    assert_update_beats_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && ld_we && ld_idx == clr_idx
        |=> tbl_valid[$past(clr_idx)] && tbl_id[$past(clr_idx)] == $past(ld_wid));

    assert_fresh_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !ld_cur_v && !st_cur_v
        |-> ld_we && st_we && ld_wid == fresh_id && st_wid == fresh_id);

    assert_merge_smaller_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && ld_cur_v && st_cur_v && ld_cur_id != st_cur_id
        |-> (ld_we != st_we) &&
            (ld_we ? (ld_wid == st_cur_id && st_cur_id < ld_cur_id)
                   : (st_wid == ld_cur_id && ld_cur_id < st_cur_id)));

    assert_quiet_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en && !clr_en |=> $stable(tbl_valid) && $stable(tbl_id));
endmodule

bind ssid_table ssid_table_chk #(
    .IDX_W(IDX_W), .SSID_W(SSID_W), .SWEEP_INTERVAL(SWEEP_INTERVAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .ld_cur_v  (ld_cur_v),
    .ld_cur_id (ld_cur_id),
    .st_cur_v  (st_cur_v),
    .st_cur_id (st_cur_id),
    .fresh_id  (fresh_id),
    .ld_we     (ld_we),
    .ld_wid    (ld_wid),
    .ld_idx    (ld_idx),
    .st_we     (st_we),
    .st_wid    (st_wid),
    .st_idx    (upd_store_pc),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .tbl_valid (tbl_valid),
    .tbl_id    (tbl_id)
);

// File: tb/tb_ssid_table.sv
module tb_ssid_table;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 4;
    localparam int SSID_W     = 4;
    localparam int ADDR_W     = 8;
    localparam int INTERVAL   = 200;
    localparam int ENTRIES    = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  rd0_pc = '0, rd1_pc = '0;
    logic              rd0_valid, rd1_valid;
    logic [SSID_W-1:0] rd0_ssid, rd1_ssid;
    logic              upd_en = 1'b0;
    logic [ADDR_W-1:0] upd_load_pc = '0;
    logic [IDX_W-1:0]  upd_store_pc = '0;

    int checks = 0;
    int errors = 0;
    int ec = 0;
    bit done = 1'b0;

    logic              mv [ENTRIES];
    logic [SSID_W-1:0] mi [ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ec <= 0;
        else        ec <= ec + 1;
    end

    ssid_table #(.IDX_W(IDX_W), .SSID_W(SSID_W), .ADDR_W(ADDR_W),
                 .SWEEP_INTERVAL(INTERVAL)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_pc(rd0_pc), .rd0_valid(rd0_valid), .rd0_ssid(rd0_ssid),
        .rd1_pc(rd1_pc), .rd1_valid(rd1_valid), .rd1_ssid(rd1_ssid),
        .upd_en(upd_en), .upd_load_pc(upd_load_pc), .upd_store_pc(upd_store_pc)
    );

    function automatic logic [SSID_W-1:0] hashf(input logic [ADDR_W-1:0] a);
        return a[SSID_W-1:0] ^ a[2*SSID_W-1:SSID_W];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (time %0t)", tag, act, exp, $time);
        end
    endtask

    // Compare one read port against the model entry.
    task automatic chk_port(input int e, input logic v, input logic [SSID_W-1:0] id,
                            input string tag);
        chk(v == mv[e], tag, int'(v), int'(mv[e]));
        if (mv[e]) chk(id == mi[e], tag, int'(id), int'(mi[e]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        upd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
            mv[i] = 1'b0;
            mi[i] = '0;
        end
    endtask

    // Whole-table readback, two entries per cycle (R11: ports independent).
    task automatic check_all(input string tag);
        for (int i = 0; i < ENTRIES/2; i++) begin
            rd0_pc = IDX_W'(2*i);
            rd1_pc = IDX_W'(2*i + 1);
            #1;
            chk_port(2*i,   rd0_valid, rd0_ssid, {tag, " R11 port0"});
            chk_port(2*i+1, rd1_valid, rd1_ssid, {tag, " R11 port1"});
            @(negedge clk);
        end
    endtask

    function automatic string model_apply(input logic [ADDR_W-1:0] lp, input int si);
        int li = int'(lp[IDX_W-1:0]);
        string tag;
        if (!mv[li] && !mv[si]) begin
            mv[li] = 1'b1; mv[si] = 1'b1;
            mi[li] = hashf(lp); mi[si] = hashf(lp);
            tag = "R3";
        end else if (mv[li] && !mv[si]) begin
            mv[si] = 1'b1; mi[si] = mi[li];
            tag = "R4";
        end else if (!mv[li] && mv[si]) begin
            mv[li] = 1'b1; mi[li] = mi[si];
            tag = "R5";
        end else if (mi[li] != mi[si]) begin
            if (mi[li] < mi[si]) mi[si] = mi[li];
            else                 mi[li] = mi[si];
            tag = "R6";
        end else begin
            tag = "R7";
        end
        return tag;
    endfunction

    // Present one violation; check the old view before the edge (R8),
    // the new view after it, then the whole table.
    task automatic update(input logic [ADDR_W-1:0] lp, input logic [IDX_W-1:0] sp,
                          input bit full);
        string tag;
        int li = int'(lp[IDX_W-1:0]);
        upd_en       = 1'b1;
        upd_load_pc  = lp;
        upd_store_pc = sp;
        rd0_pc       = lp[IDX_W-1:0];
        rd1_pc       = sp;
        #1;
        chk_port(li, rd0_valid, rd0_ssid, "R8 old load view");
        chk_port(int'(sp), rd1_valid, rd1_ssid, "R8 old store view");
        tag = model_apply(lp, int'(sp));
        @(negedge clk);
        upd_en = 1'b0;
        #1;
        chk_port(li, rd0_valid, rd0_ssid, {tag, " R8 load entry"});
        chk_port(int'(sp), rd1_valid, rd1_ssid, {tag, " R8 store entry"});
        @(negedge clk);
        if (full) check_all({tag, " R7 table"});
    endtask

    task automatic wait_ec(input int n);
        while (ec != n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        do_reset();
        check_all("R1 reset");

        // Directed walk through every assignment rule.
        update(8'h14, 4'h8, 1'b1);   // fresh set, id 5 (R3)
        update(8'h2C, 4'h8, 1'b1);   // only store valid (R5)
        update(8'h14, 4'h2, 1'b1);   // only load valid (R4)
        update(8'hE1, 4'h6, 1'b1);   // fresh set, id F (R3)
        update(8'h06, 4'h8, 1'b1);   // merge, store smaller (R6)
        update(8'h31, 4'h9, 1'b1);   // load aliases entry 1 via upper bits (R2)
        rd0_pc = 4'h9; #1;
        chk(rd0_valid && rd0_ssid == 4'hF, "R2 aliased load entry shared", int'(rd0_ssid), 15);
        @(negedge clk);
        update(8'h04, 4'h9, 1'b1);   // merge, load smaller (R6)
        update(8'h14, 4'h8, 1'b1);   // same set, no change (R7)

        // Arithmetic sweep of address pairs, fresh table per batch.
        for (int t = 0; t < 6; t++) begin
            do_reset();
            for (int k = 0; k < 10; k++) begin
                update(ADDR_W'(t*53 + k*29 + 7), IDX_W'(t*11 + k*5 + 3), 1'b1);
            end
        end

        // Sweep timing (R9) and update-over-sweep priority (R10).
        do_reset();
        for (int i = 0; i < 8; i++) begin
            if (i != 2 && i != 3) begin
                logic [ADDR_W-1:0] lp;
                lp = {IDX_W'(i + 3), IDX_W'(i)};
                update(lp, IDX_W'(i + 8), 1'b0);
            end
        end
        wait_ec(INTERVAL + 5);
        rd0_pc = 4'd5; rd1_pc = 4'd6; #1;
        chk(rd0_valid == 1'b1, "R9 entry 5 before its clear edge", int'(rd0_valid), 1);
        chk(rd1_valid == 1'b1, "R9 entry 6 before its clear edge", int'(rd1_valid), 1);
        @(negedge clk); #1;
        chk(rd0_valid == 1'b0, "R9 entry 5 cleared at edge I+6", int'(rd0_valid), 0);
        chk(rd1_valid == 1'b1, "R9 entry 6 still valid at edge I+6", int'(rd1_valid), 1);
        wait_ec(INTERVAL + 10);
        upd_en = 1'b1; upd_load_pc = 8'h5A; upd_store_pc = 4'd11;
        @(negedge clk);
        upd_en = 1'b0;
        rd0_pc = 4'd10; rd1_pc = 4'd11; #1;
        chk(rd0_valid == 1'b1 && rd0_ssid == 4'hF, "R10 update wins over sweep",
            int'({rd0_valid, rd0_ssid}), 'h1F);
        chk(rd1_valid == 1'b1 && rd1_ssid == 4'hF, "R3 store entry during sweep",
            int'({rd1_valid, rd1_ssid}), 'h1F);
        @(negedge clk); #1;
        chk(rd1_valid == 1'b0, "R9 entry 11 cleared at edge I+12", int'(rd1_valid), 0);
        chk(rd0_valid == 1'b1, "R10 entry 10 survives", int'(rd0_valid), 1);
        wait_ec(INTERVAL + ENTRIES);
        for (int i = 0; i < ENTRIES; i++) mv[i] = 1'b0;
        mv[10] = 1'b1; mi[10] = 4'hF;
        check_all("R9 after full sweep");
        wait_ec(2*INTERVAL + ENTRIES + 10);
        rd0_pc = 4'd10; #1;
        chk(rd0_valid == 1'b1, "R9 entry 10 before second sweep edge", int'(rd0_valid), 1);
        @(negedge clk); #1;
        chk(rd0_valid == 1'b0, "R9 entry 10 cleared by second sweep", int'(rd0_valid), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule